// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter with Alarm

This block keeps wall-clock time and date for a real-time clock. It holds seconds, minutes, hours, day of week, day of month, month and a two-digit year, together with three alarm bytes for second, minute and hour. A prescaler divides the system clock down to a one-second tick. Each tick advances the time with full carry through the calendar, opens an update-in-progress window just before it, and emits a one-cycle update-ended pulse. A one-cycle alarm pulse follows when the alarm bytes match the new time.

Three configuration pins select how fields are presented: plain binary or packed BCD, 24-hour or 12-hour with a PM flag, and a freeze bit that stops time so software can load a consistent value. Register writes and reads use a 4-bit index. A write is a single-cycle strobe that is always accepted. There is no back-pressure and no valid/ready handshake, because the block can absorb one write every cycle. Reads are combinational from the index.

Top module: `rtc_time_core`

## Requirements
- R1: After reset, time reads 00:00:00, day of week 1, day of month 1, month 1, year 0. All three alarm bytes read 0x00, and `uip`, `upd_pulse` and `alarm_pulse` are low.
- R2: With `cfg_binary`=0, each field is packed BCD, with tens in bits 7:4 and units in bits 3:0. With `cfg_binary`=1, a field holds the plain value. The mode applies both to decoding writes and to encoding reads.
- R3: With `cfg_24h`=0, the hours field reads 1..12, where 12 stands for internal hour 0 or 12. Bit 7 is set for internal hours 12..23. A write in this mode is decoded the same way.
- R4: Each one-second tick advances seconds. Seconds wrap from 59 to 0 and carry into minutes. Minutes wrap from 59 to 0 and carry into hours. Hours wrap from 23 to 0 and carry into the date.
- R5: On a date carry, day of week advances 1..7 and wraps to 1. Day of month wraps to 1 after the month's last day: 30 for months 4, 6, 9 and 11; 28 for February, or 29 when the year is divisible by 4; 31 otherwise. The month then advances.
- R6: Month wraps from 12 to 1 and carries into the year. The year wraps from 99 to 0.
- R7: With N = `CLKS_PER_SEC` and W = max(1, floor(N*244/1e6)), `uip` is high in the last W cycles of each N-cycle second. `upd_pulse` is high for exactly one cycle, the cycle after the window closes, and the time is already advanced in that cycle.
- R8: While `cfg_set`=1, time does not advance, `uip` stays 0, and neither pulse fires. The prescaler is held at the start of a second, so the first `upd_pulse` comes N cycles after `cfg_set` falls.
- R9: A write takes effect on the next clock edge and overrides any count in that cycle. The write index map is 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 day of month, 5 month, 6 year, 8 alarm second, 9 alarm minute, 10 alarm hour. Any other index is ignored on write and reads 0x00. After `cfg_set` falls, counting resumes from the written values.
- R10: `alarm_pulse` rises for one cycle, the cycle after `upd_pulse`, when every non-wildcard alarm field equals the current field. The alarm field is decoded in the current mode.
- R11: An alarm byte with bits 7:6 = 11 is a wildcard and matches any value. With all three alarm bytes set as wildcards, the alarm fires every second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_set | input | 1 | Freeze time and events while high |
| cfg_binary | input | 1 | 1 = plain binary fields, 0 = packed BCD |
| cfg_24h | input | 1 | 1 = 24-hour hours field, 0 = 12-hour with PM flag |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_idx | input | 4 | Register index for the write |
| wr_data | input | 8 | Encoded write value |
| rd_idx | input | 4 | Register index for the read |
| rd_data | output | 8 | Encoded value of the indexed register |
| uip | output | 1 | Update-in-progress window |
| upd_pulse | output | 1 | One-cycle pulse after each time update |
| alarm_pulse | output | 1 | One-cycle pulse on alarm match |

## Verification
The rare events are the carries that cross a day, month or year boundary: the February 29 versus March 1 choice and the wrap from 99 to 0. From reset, reaching them would take simulated days. The bench instead freezes the counter, writes a time one second before each boundary, releases the freeze and waits one short second, set by a small `CLKS_PER_SEC`. The cycle-exact position of the update window is then measured from the release edge. This is possible because the freeze holds the prescaler at the start of a second.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef enum logic [3:0] {
    IDX_SEC   = 4'd0,
    IDX_MIN   = 4'd1,
    IDX_HOUR  = 4'd2,
    IDX_WDAY  = 4'd3,
    IDX_MDAY  = 4'd4,
    IDX_MON   = 4'd5,
    IDX_YEAR  = 4'd6,
    IDX_ASEC  = 4'd8,
    IDX_AMIN  = 4'd9,
    IDX_AHOUR = 4'd10
  } reg_idx_e;

  // Internal time is always kept in plain binary.
  typedef struct packed {
    logic [5:0] sec;
    logic [5:0] min;
    logic [4:0] hour;
    logic [2:0] wday;
    logic [4:0] mday;
    logic [3:0] mon;
    logic [6:0] year;
  } cal_t;

  function automatic logic [7:0] to_field(input logic [6:0] v, input logic bin);
    logic [3:0] tens;
    logic [3:0] units;
    tens  = 4'(v / 7'd10);
    units = 4'(v % 7'd10);
    return bin ? {1'b0, v} : {tens, units};
  endfunction

  function automatic logic [6:0] from_field(input logic [7:0] f, input logic bin);
    logic [7:0] t;
    t = ({4'b0, f[7:4]} * 8'd10) + {4'b0, f[3:0]};
    return bin ? f[6:0] : t[6:0];
  endfunction

  function automatic logic [7:0] hour_to_field(input logic [4:0] h, input logic bin,
                                               input logic h24);
    logic [4:0] h12;
    logic       pm;
    pm  = (h >= 5'd12);
    h12 = pm ? (h - 5'd12) : h;
    if (h12 == 5'd0) h12 = 5'd12;
    if (h24) return to_field({2'b0, h}, bin);
    return {pm, 7'b0} | to_field({2'b0, h12}, bin);
  endfunction

  function automatic logic [4:0] hour_from_field(input logic [7:0] f, input logic bin,
                                                 input logic h24);
    logic [6:0] v;
    logic [4:0] h;
    v = from_field({1'b0, f[6:0]}, bin);
    if (h24) return v[4:0];
    h = (v == 7'd12) ? 5'd0 : v[4:0];
    return f[7] ? (h + 5'd12) : h;
  endfunction

  function automatic logic [4:0] month_days(input logic [3:0] mon, input logic [6:0] yr);
    case (mon)
      4'd2:                   return (yr[1:0] == 2'b00) ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11: return 5'd30;
      default:                return 5'd31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_sec_timer.sv
module rtc_sec_timer #(
  parameter int unsigned CLKS_PER_SEC = 32768,
  parameter int unsigned UIP_CYCLES   = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic freeze_i,
  output logic tick_o,
  output logic uip_o
);
  localparam int unsigned CNT_W = (CLKS_PER_SEC > 2) ? $clog2(CLKS_PER_SEC) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT  = CNT_W'(CLKS_PER_SEC - 1);
  localparam logic [CNT_W-1:0] WIN_START = CNT_W'(CLKS_PER_SEC - UIP_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (freeze_i)          cnt_q <= '0;
    else if (cnt_q == LAST_CNT) cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = !freeze_i && (cnt_q == LAST_CNT);
  assign uip_o  = !freeze_i && (cnt_q >= WIN_START);

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       cfg_binary_i,
  input  logic       cfg_24h_i,
  input  logic       wr_en_i,
  input  logic [3:0] wr_idx_i,
  input  logic [7:0] wr_data_i,
  output cal_t       cur_o,
  output logic       upd_o
);
  cal_t       cur_q;
  cal_t       nxt;
  logic [4:0] dim;
  logic [6:0] wv;
  logic [4:0] wh;

  assign dim = month_days(cur_q.mon, cur_q.year);
  assign wv  = from_field(wr_data_i, cfg_binary_i);
  assign wh  = hour_from_field(wr_data_i, cfg_binary_i, cfg_24h_i);

  always_comb begin
    nxt = cur_q;
    if (tick_i) begin
      if (cur_q.sec >= 6'd59) begin
        nxt.sec = 6'd0;
        if (cur_q.min >= 6'd59) begin
          nxt.min = 6'd0;
          if (cur_q.hour >= 5'd23) begin
            nxt.hour = 5'd0;
            nxt.wday = (cur_q.wday >= 3'd7) ? 3'd1 : (cur_q.wday + 3'd1);
            if (cur_q.mday >= dim) begin
              nxt.mday = 5'd1;
              if (cur_q.mon >= 4'd12) begin
                nxt.mon  = 4'd1;
                nxt.year = (cur_q.year >= 7'd99) ? 7'd0 : (cur_q.year + 7'd1);
              end else begin
                nxt.mon = cur_q.mon + 4'd1;
              end
            end else begin
              nxt.mday = cur_q.mday + 5'd1;
            end
          end else begin
            nxt.hour = cur_q.hour + 5'd1;
          end
        end else begin
          nxt.min = cur_q.min + 6'd1;
        end
      end else begin
        nxt.sec = cur_q.sec + 6'd1;
      end
    end
    if (wr_en_i) begin
      case (wr_idx_i)
        IDX_SEC:  nxt.sec  = wv[5:0];
        IDX_MIN:  nxt.min  = wv[5:0];
        IDX_HOUR: nxt.hour = wh;
        IDX_WDAY: nxt.wday = wv[2:0];
        IDX_MDAY: nxt.mday = wv[4:0];
        IDX_MON:  nxt.mon  = wv[3:0];
        IDX_YEAR: nxt.year = wv;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '{sec: 6'd0, min: 6'd0, hour: 5'd0, wday: 3'd1,
                 mday: 5'd1, mon: 4'd1, year: 7'd0};
      upd_o <= 1'b0;
    end else begin
      cur_q <= nxt;
      upd_o <= tick_i;
    end
  end

  assign cur_o = cur_q;

  // R4
  sec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i && !wr_en_i && (cur_q.sec < 6'd59) |=> cur_q.sec == ($past(cur_q.sec) + 6'd1));

  // R8
  hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i && !wr_en_i |=> cur_q == $past(cur_q));

  // R6
  month_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i && !wr_en_i && (cur_q.mon == 4'd12) && (cur_q.mday >= dim) &&
    (cur_q.hour == 5'd23) && (cur_q.min == 6'd59) && (cur_q.sec == 6'd59)
    |=> cur_q.mon == 4'd1);

endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
  import rtc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_binary_i,
  input  logic            cfg_24h_i,
  input  logic            wr_en_i,
  input  logic [3:0]      wr_idx_i,
  input  logic [7:0]      wr_data_i,
  input  cal_t            cur_i,
  input  logic            upd_i,
  output logic [2:0][7:0] alm_o,
  output logic            alarm_o
);
  localparam int unsigned NFIELDS = 3;

  logic [6:0]         cur_f [NFIELDS];
  logic [NFIELDS-1:0] hit;

  assign cur_f[0] = {1'b0, cur_i.sec};
  assign cur_f[1] = {1'b0, cur_i.min};
  assign cur_f[2] = {2'b0, cur_i.hour};

  for (genvar i = 0; i < NFIELDS; i++) begin : g_field
    localparam logic [3:0] FIELD_IDX = 4'(int'(IDX_ASEC) + i);
    logic [7:0] q;
    logic [6:0] dec;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                q <= 8'h00;
      else if (wr_en_i && wr_idx_i == FIELD_IDX) q <= wr_data_i;
    end

    if (i == NFIELDS - 1) begin : g_hour
      assign dec = {2'b0, hour_from_field(q, cfg_binary_i, cfg_24h_i)};
    end else begin : g_plain
      assign dec = from_field(q, cfg_binary_i);
    end

    assign hit[i]   = (q[7:6] == 2'b11) || (dec == cur_f[i]);
    assign alm_o[i] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) alarm_o <= 1'b0;
    else        alarm_o <= upd_i && (&hit);
  end

  // R10
  alarm_follows_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_o |-> $past(upd_i));

  // R11
  all_wild_fires_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_i && (alm_o[0][7:6] == 2'b11) && (alm_o[1][7:6] == 2'b11) &&
    (alm_o[2][7:6] == 2'b11) && !wr_en_i |=> alarm_o);

endmodule

// File: rtl/rtc_reg_view.sv
module rtc_reg_view
  import rtc_pkg::*;
(
  input  logic            cfg_binary_i,
  input  logic            cfg_24h_i,
  input  logic [3:0]      rd_idx_i,
  input  cal_t            cur_i,
  input  logic [2:0][7:0] alm_i,
  output logic [7:0]      rd_data_o
);
  always_comb begin
    case (rd_idx_i)
      IDX_SEC:   rd_data_o = to_field({1'b0, cur_i.sec}, cfg_binary_i);
      IDX_MIN:   rd_data_o = to_field({1'b0, cur_i.min}, cfg_binary_i);
      IDX_HOUR:  rd_data_o = hour_to_field(cur_i.hour, cfg_binary_i, cfg_24h_i);
      IDX_WDAY:  rd_data_o = to_field({4'b0, cur_i.wday}, cfg_binary_i);
      IDX_MDAY:  rd_data_o = to_field({2'b0, cur_i.mday}, cfg_binary_i);
      IDX_MON:   rd_data_o = to_field({3'b0, cur_i.mon}, cfg_binary_i);
      IDX_YEAR:  rd_data_o = to_field(cur_i.year, cfg_binary_i);
      IDX_ASEC:  rd_data_o = alm_i[0];
      IDX_AMIN:  rd_data_o = alm_i[1];
      IDX_AHOUR: rd_data_o = alm_i[2];
      default:   rd_data_o = 8'h00;
    endcase
  end
endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core
  import rtc_pkg::*;
#(
  parameter int unsigned CLKS_PER_SEC = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_set,
  input  logic       cfg_binary,
  input  logic       cfg_24h,
  input  logic       wr_en,
  input  logic [3:0] wr_idx,
  input  logic [7:0] wr_data,
  input  logic [3:0] rd_idx,
  output logic [7:0] rd_data,
  output logic       uip,
  output logic       upd_pulse,
  output logic       alarm_pulse
);
  localparam longint unsigned UIP_RAW = (64'(CLKS_PER_SEC) * 64'd244) / 64'd1000000;
  localparam int unsigned UIP_CYCLES  = (UIP_RAW == 64'd0) ? 1 : int'(UIP_RAW);

  logic            tick;
  cal_t            cur;
  logic [2:0][7:0] alm;

  rtc_sec_timer #(
    .CLKS_PER_SEC(CLKS_PER_SEC),
    .UIP_CYCLES  (UIP_CYCLES)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .freeze_i(cfg_set),
    .tick_o  (tick),
    .uip_o   (uip)
  );

  rtc_calendar u_cal (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick),
    .cfg_binary_i(cfg_binary),
    .cfg_24h_i   (cfg_24h),
    .wr_en_i     (wr_en),
    .wr_idx_i    (wr_idx),
    .wr_data_i   (wr_data),
    .cur_o       (cur),
    .upd_o       (upd_pulse)
  );

  rtc_alarm u_alarm (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_binary_i(cfg_binary),
    .cfg_24h_i   (cfg_24h),
    .wr_en_i     (wr_en),
    .wr_idx_i    (wr_idx),
    .wr_data_i   (wr_data),
    .cur_i       (cur),
    .upd_i       (upd_pulse),
    .alm_o       (alm),
    .alarm_o     (alarm_pulse)
  );

  rtc_reg_view u_view (
    .cfg_binary_i(cfg_binary),
    .cfg_24h_i   (cfg_24h),
    .rd_idx_i    (rd_idx),
    .cur_i       (cur),
    .alm_i       (alm),
    .rd_data_o   (rd_data)
  );

  // R7
  upd_after_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_pulse |-> $past(uip));

  // R7
  upd_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_pulse |=> !upd_pulse);

  // R8
  frozen_no_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_set |=> !upd_pulse);

endmodule

// File: tb/test_rtc_time_core.sv
module test_rtc_time_core;
  localparam int CPS = 8200;   // window = floor(8200*244/1e6) = 2 cycles
  localparam int WIN = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_set = 1'b1;
  logic       cfg_binary = 1'b0;
  logic       cfg_24h = 1'b1;
  logic       wr_en = 1'b0;
  logic [3:0] wr_idx = 4'd0;
  logic [7:0] wr_data = 8'd0;
  logic [3:0] rd_idx = 4'd0;
  logic [7:0] rd_data;
  logic       uip, upd_pulse, alarm_pulse;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  rtc_time_core #(.CLKS_PER_SEC(CPS)) i_rtc_time_core (
    .clk(clk), .rst_n(rst_n), .cfg_set(cfg_set), .cfg_binary(cfg_binary),
    .cfg_24h(cfg_24h), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .uip(uip), .upd_pulse(upd_pulse),
    .alarm_pulse(alarm_pulse)
  );

  typedef struct packed {
    logic       bin;
    logic       h24;
    logic [6:0] s, m, h, wd, md, mo, yr;
    logic [6:0] es, em, eh, ewd, emd, emo, eyr;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b0, 1'b1, 7'd59, 7'd59, 7'd23, 7'd7, 7'd31, 7'd12, 7'd99,
      7'd0, 7'd0, 7'd0, 7'd1, 7'd1, 7'd1, 7'd0},
    '{1'b0, 1'b1, 7'd59, 7'd59, 7'd23, 7'd3, 7'd28, 7'd2, 7'd24,
      7'd0, 7'd0, 7'd0, 7'd4, 7'd29, 7'd2, 7'd24},
    '{1'b0, 1'b1, 7'd59, 7'd59, 7'd23, 7'd3, 7'd28, 7'd2, 7'd23,
      7'd0, 7'd0, 7'd0, 7'd4, 7'd1, 7'd3, 7'd23},
    '{1'b0, 1'b1, 7'd59, 7'd59, 7'd23, 7'd5, 7'd30, 7'd4, 7'd10,
      7'd0, 7'd0, 7'd0, 7'd6, 7'd1, 7'd5, 7'd10},
    '{1'b0, 1'b0, 7'd59, 7'd59, 7'd11, 7'd2, 7'd9, 7'd9, 7'd9,
      7'd0, 7'd0, 7'd12, 7'd2, 7'd9, 7'd9, 7'd9},
    '{1'b1, 1'b1, 7'd59, 7'd59, 7'd23, 7'd4, 7'd31, 7'd1, 7'd50,
      7'd0, 7'd0, 7'd0, 7'd5, 7'd1, 7'd2, 7'd50},
    '{1'b1, 1'b0, 7'd59, 7'd29, 7'd13, 7'd1, 7'd5, 7'd5, 7'd5,
      7'd0, 7'd30, 7'd13, 7'd1, 7'd5, 7'd5, 7'd5},
    '{1'b0, 1'b1, 7'd59, 7'd59, 7'd23, 7'd6, 7'd29, 7'd2, 7'd0,
      7'd0, 7'd0, 7'd0, 7'd7, 7'd1, 7'd3, 7'd0}
  };

  // R2 encoding as seen at the ports
  function automatic logic [7:0] enc(input int v, input logic bin);
    return bin ? 8'(v) : 8'(((v / 10) << 4) | (v % 10));
  endfunction

  // R3 12-hour view: 1..12, bit 7 for PM
  function automatic logic [7:0] enc_hour(input int h, input logic bin, input logic h24);
    int hh;
    if (h24) return enc(h, bin);
    hh = h % 12;
    if (hh == 0) hh = 12;
    return ((h >= 12) ? 8'h80 : 8'h00) | enc(hh, bin);
  endfunction

  task automatic wr(input logic [3:0] idx, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic chk_rd(input logic [3:0] idx, input logic [7:0] exp, input string tag);
    @(negedge clk);
    rd_idx = idx;
    #1;
    total++;
    if (rd_data !== exp) begin
      bad++;
      $display("FAIL %s idx=%0d act=%02h exp=%02h", tag, idx, rd_data, exp);
    end
  endtask

  task automatic chk_bit(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0b exp=%0b", tag, act, exp);
    end
  endtask

  task automatic load_time(input logic bin, input logic h24, input int s, input int m,
                           input int h, input int wd, input int md, input int mo,
                           input int yr);
    @(negedge clk);
    cfg_set = 1'b1; cfg_binary = bin; cfg_24h = h24;
    wr(4'd0, enc(s, bin));
    wr(4'd1, enc(m, bin));
    wr(4'd2, enc_hour(h, bin, h24));
    wr(4'd3, enc(wd, bin));
    wr(4'd4, enc(md, bin));
    wr(4'd5, enc(mo, bin));
    wr(4'd6, enc(yr, bin));
  endtask

  task automatic release_set();
    @(negedge clk);
    cfg_set = 1'b0;
  endtask

  task automatic wait_upd();
    int g;
    g = 0;
    do begin
      @(negedge clk);
      g++;
    end while (!upd_pulse && g < 3 * CPS);
  endtask

  // watchdog
  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog R7 act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    vec_t v;
    int   cnt_ev;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state (BCD, 24h, frozen)
    chk_rd(4'd0, 8'h00, "R1 sec");
    chk_rd(4'd1, 8'h00, "R1 min");
    chk_rd(4'd2, 8'h00, "R1 hour");
    chk_rd(4'd3, 8'h01, "R1 wday");
    chk_rd(4'd4, 8'h01, "R1 mday");
    chk_rd(4'd5, 8'h01, "R1 mon");
    chk_rd(4'd6, 8'h00, "R1 year");
    chk_rd(4'd8, 8'h00, "R1 alarm sec");
    chk_rd(4'd9, 8'h00, "R1 alarm min");
    chk_rd(4'd10, 8'h00, "R1 alarm hour");
    chk_bit(uip, 1'b0, "R1 uip");
    chk_bit(upd_pulse, 1'b0, "R1 upd");
    chk_bit(alarm_pulse, 1'b0, "R1 alarm");

    // R7 R8 window placement measured from release of the freeze
    load_time(1'b0, 1'b1, 0, 0, 0, 1, 1, 1, 0);
    release_set();
    repeat (CPS - WIN - 1) @(negedge clk);
    chk_bit(uip, 1'b0, "R7 uip before window");
    @(negedge clk);
    chk_bit(uip, 1'b1, "R7 uip window start");
    chk_bit(upd_pulse, 1'b0, "R7 no upd inside window");
    repeat (WIN - 1) @(negedge clk);
    chk_bit(uip, 1'b1, "R7 uip window end");
    @(negedge clk);
    chk_bit(uip, 1'b0, "R7 uip closed");
    chk_bit(upd_pulse, 1'b1, "R8 R7 upd after one full second");
    @(negedge clk);
    chk_bit(upd_pulse, 1'b0, "R7 upd one cycle");
    chk_rd(4'd0, 8'h01, "R4 sec advanced");

    // R8 freeze: nothing moves, no events, even with all-wildcard alarm
    load_time(1'b0, 1'b1, 30, 20, 10, 2, 3, 4, 5);
    wr(4'd8, 8'hC0); wr(4'd9, 8'hC0); wr(4'd10, 8'hC0);
    cnt_ev = 0;
    repeat (CPS + 100) begin
      @(negedge clk);
      if (uip || upd_pulse || alarm_pulse) cnt_ev++;
    end
    total++;
    if (cnt_ev != 0) begin
      bad++;
      $display("FAIL R8 events while frozen act=%0d exp=0", cnt_ev);
    end
    chk_rd(4'd0, 8'h30, "R8 sec frozen");
    chk_rd(4'd2, 8'h10, "R8 hour frozen");
    wr(4'd8, 8'h00); wr(4'd9, 8'h00); wr(4'd10, 8'h00);

    // Vector table: R2 R3 R4 R5 R6 carries across boundaries
    for (int i = 0; i < 8; i++) begin
      v = VECS[i];
      load_time(v.bin, v.h24, int'(v.s), int'(v.m), int'(v.h), int'(v.wd),
                int'(v.md), int'(v.mo), int'(v.yr));
      release_set();
      wait_upd();
      chk_rd(4'd0, enc(int'(v.es), v.bin), "R4 R2 vec sec");
      chk_rd(4'd1, enc(int'(v.em), v.bin), "R4 vec min");
      chk_rd(4'd2, enc_hour(int'(v.eh), v.bin, v.h24), "R3 R4 vec hour");
      chk_rd(4'd3, enc(int'(v.ewd), v.bin), "R5 vec wday");
      chk_rd(4'd4, enc(int'(v.emd), v.bin), "R5 vec mday");
      chk_rd(4'd5, enc(int'(v.emo), v.bin), "R6 R5 vec mon");
      chk_rd(4'd6, enc(int'(v.eyr), v.bin), "R6 vec year");
    end

    // R3 12-hour write decode: 0x12 is midnight, 0x92 is noon
    load_time(1'b0, 1'b0, 0, 0, 0, 1, 1, 1, 0);
    wr(4'd2, 8'h12);
    cfg_24h = 1'b1;
    chk_rd(4'd2, 8'h00, "R3 12AM decodes to 0");
    cfg_24h = 1'b0;
    wr(4'd2, 8'h92);
    cfg_24h = 1'b1;
    chk_rd(4'd2, 8'h12, "R3 12PM decodes to 12");

    // R10 exact alarm match, pulse one cycle after update
    load_time(1'b0, 1'b1, 59, 14, 8, 1, 1, 1, 0);
    wr(4'd8, 8'h00); wr(4'd9, 8'h15); wr(4'd10, 8'h08);
    release_set();
    wait_upd();
    chk_bit(alarm_pulse, 1'b0, "R10 alarm not with upd");
    @(negedge clk);
    chk_bit(alarm_pulse, 1'b1, "R10 alarm match");
    @(negedge clk);
    chk_bit(alarm_pulse, 1'b0, "R10 alarm one cycle");

    // R10 mismatch then match one second later
    load_time(1'b0, 1'b1, 59, 14, 8, 1, 1, 1, 0);
    wr(4'd8, 8'h01);
    release_set();
    wait_upd();
    @(negedge clk);
    chk_bit(alarm_pulse, 1'b0, "R10 alarm mismatch");
    wait_upd();
    @(negedge clk);
    chk_bit(alarm_pulse, 1'b1, "R10 alarm at :01");

    // R11 all wildcards: fires every second
    load_time(1'b0, 1'b1, 4, 7, 3, 1, 1, 1, 0);
    wr(4'd8, 8'hC0); wr(4'd9, 8'hC0); wr(4'd10, 8'hC0);
    release_set();
    wait_upd();
    @(negedge clk);
    chk_bit(alarm_pulse, 1'b1, "R11 wildcard first second");
    wait_upd();
    @(negedge clk);
    chk_bit(alarm_pulse, 1'b1, "R11 wildcard second second");

    // R11 partial wildcard: hour and minute ignored, seconds must match
    load_time(1'b0, 1'b1, 4, 7, 3, 1, 1, 1, 0);
    wr(4'd8, 8'h05); wr(4'd9, 8'hC3); wr(4'd10, 8'hFF);
    release_set();
    wait_upd();
    @(negedge clk);
    chk_bit(alarm_pulse, 1'b1, "R11 partial wildcard");

    // R9 write while running overrides, counting resumes from it
    wr(4'd0, 8'h45);
    chk_rd(4'd0, 8'h45, "R9 running write");
    chk_rd(4'd1, 8'h07, "R9 min before unmapped write");
    wr(4'd7, 8'h55);
    wr(4'd15, 8'h33);
    chk_rd(4'd7, 8'h00, "R9 unmapped read 7");
    chk_rd(4'd15, 8'h00, "R9 unmapped read 15");
    chk_rd(4'd1, 8'h07, "R9 min untouched by unmapped write");
    wait_upd();
    chk_rd(4'd0, 8'h46, "R9 R4 counts from written value");

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule